// File: doc/BRIEF.md
# Receive Dibit Elasticity Buffer

This block connects a receive data path running on a recovered line clock to logic running on a local 50 MHz reference clock. Dibits enter on the recovered clock while a receive-valid level is high. They leave as dibits on the reference clock. Inside is a 32-bit dual-clock FIFO. Its write and read positions cross between the two domains as Gray-coded counts through multi-flop synchronisers.

Output for a packet does not begin as soon as data arrives. The read side waits until the buffered amount reaches a start level chosen by a 2-bit code. A low level gives short latency but absorbs little drift between the two clocks. A high level adds latency and allows longer packets before the FIFO runs dry or fills up. As a guide, settings of 4, 8, 12 and 16 bits absorb about 2, 6, 10 and 14 bits of drift. With both clocks at ±100 ppm, that covers packets of roughly 1200, 3600, 6000 and 8400 bytes. At ±50 ppm the figures double.

When the receive-valid level falls, the write side stores an end marker behind the last dibit. The read side keeps its output valid until it reaches that marker. If the FIFO overflows or runs dry inside a packet, the rest of that packet goes out bit-inverted, so its frame check fails downstream. A sticky status flag records which fault occurred.

Top module: `rmii_rx_elastic`

## Requirements
- R1: While either reset is asserted and just after it is released, `out_valid` is 0 and both status flags are 0.
- R2: Write and read positions cross domains as Gray-coded counts through synchronisers of `SYNC_STAGES` flops. A position copy seen in the other domain never moves backwards and never advances by more than the FIFO depth.
- R3: The start code on `thr_code` sets the start level: code 1 = 4 bits (2 dibits), code 2 = 8 bits, code 3 = 12 bits, code 0 = 16 bits. For a packet, `out_valid` stays 0 while fewer dibits than the start level are buffered. It rises once the level is reached.
- R4: Without a fault, dibits leave in the order they were written, with unchanged values, and neither status flag is set.
- R5: Once raised for a packet, `out_valid` stays high without a gap until every buffered dibit of that packet has left. It then falls, and the next packet must reach the start level again.
- R6: If the FIFO is found empty inside a packet before its end marker, `stat_underrun` is set. The output dibit is replaced by the bitwise complement of the last one sent, and `out_valid` stays high. Every later dibit of that packet leaves complemented, until the end marker drops `out_valid`.
- R7: A dibit offered while the FIFO is full is dropped and `stat_overrun` is set. Dibits of that packet leaving after the fault is seen are bitwise complemented, and `out_valid` stays high until the end marker.
- R8: Both status flags are sticky and are cleared by a one-cycle `stat_clr` pulse on the reference clock. A fault in the same cycle wins over the clear.
- R9: The FIFO never holds more than 32 bits (16 dibits). The read side never sees a fill above that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock (write domain) |
| rx_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| rx_valid | input | 1 | High while a packet's dibits are being delivered |
| rx_dibit | input | 2 | Receive dibit, taken on each `rx_clk` edge with `rx_valid` high |
| ref_clk | input | 1 | 50 MHz reference clock (read domain) |
| ref_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| thr_code | input | 2 | Start level code (see R3) |
| stat_clr | input | 1 | One-cycle clear strobe for the status flags |
| out_valid | output | 1 | Output dibit valid |
| out_dibit | output | 2 | Output dibit, complemented after a fault |
| stat_overrun | output | 1 | Sticky overrun flag |
| stat_underrun | output | 1 | Sticky underrun flag |

## Verification
The assertions take several things for granted. `thr_code` is held steady for the whole of a packet. Packets are at least as long as the start level. Consecutive packets are separated by an idle gap long enough for the previous end marker to be read. The position checks also assume the recovered clock is only gated or slowed, never glitched. The stimulus follows all of this. The start code changes only while the block is idle. Every packet is longer than the start level, except in the start-level test, which goes on to close its packet. The bench waits for `out_valid` to fall and a few more cycles before starting the next packet. Faults are provoked only by stopping the recovered clock mid-packet or by running it far faster than the reference clock.

// File: rtl/rmii_eb_pkg.sv
package rmii_eb_pkg;

   localparam int DIBIT_W = 2;

   typedef struct packed {
      logic               eop;
      logic [DIBIT_W-1:0] d;
   } eb_entry_t;

   // start level in bits for a code; code 0 selects the largest level
   function automatic int unsigned start_bits(input logic [1:0] code, input int unsigned step);
      return (code == 2'd0) ? 4 * step : int'(code) * step;
   endfunction

endpackage

// File: rtl/eb_sync.sv
module eb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2,
   parameter bit GRAY   = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] pipe;
   logic [W-1:0]             raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign raw = pipe[STAGES-1];

   generate
      if (GRAY) begin : g_gray
         always_comb begin
            logic acc;
            acc = 1'b0;
            for (int i = W - 1; i >= 0; i--) begin
               acc  = acc ^ raw[i];
               q[i] = acc;
            end
         end

         assert_ptr_forward_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            (q - $past(q)) <= W'(2 ** (W - 1)))
            else $error("synchronised position moved backwards or too far");
      end else begin : g_plain
         assign q = raw;
      end
   endgenerate

endmodule

// File: rtl/eb_mem.sv
module eb_mem #(
   parameter int DEPTH = 16,
   parameter int EW    = 3,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [EW-1:0] rdata
);

   logic [EW-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl import rmii_eb_pkg::*; #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [DIBIT_W-1:0] rx_dibit,
   input  logic [PW-1:0]      rptr_bin,
   output logic               we,
   output logic [AW-1:0]      waddr,
   output eb_entry_t          wdata,
   output logic [PW-1:0]      wptr_gray,
   output logic               ovr_tog
);

   logic [PW-1:0] wptr_bin, wptr_nxt, used;
   logic          prev_valid, eop_pend, ovr_seen;
   logic          full, pkt_start, want_eop, overrun_now;

   assign used     = wptr_bin - rptr_bin;
   assign full     = (used == PW'(DEPTH));
   assign wptr_nxt = wptr_bin + PW'(1);
   assign waddr    = wptr_bin[AW-1:0];

   always_comb begin
      pkt_start   = rx_valid & ~prev_valid;
      want_eop    = eop_pend | (prev_valid & ~rx_valid);
      we          = ~full & (want_eop | rx_valid);
      wdata.eop   = want_eop;
      wdata.d     = want_eop ? '0 : rx_dibit;
      overrun_now = rx_valid & (full | want_eop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_bin   <= '0;
         wptr_gray  <= '0;
         prev_valid <= 1'b0;
         eop_pend   <= 1'b0;
         ovr_seen   <= 1'b0;
         ovr_tog    <= 1'b0;
      end else begin
         if (we) begin
            wptr_bin  <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
         end
         prev_valid <= rx_valid;
         eop_pend   <= want_eop & full;
         // one event per packet is enough to reach the read side
         if (overrun_now && (!ovr_seen || pkt_start)) ovr_tog <= ~ovr_tog;
         ovr_seen <= pkt_start ? overrun_now : (ovr_seen | overrun_now);
      end
   end

   assert_ovr_in_pkt_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ovr_tog) |-> $past(rx_valid))
      else $error("overrun event raised outside a packet");

endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl import rmii_eb_pkg::*; #(
   parameter int DEPTH    = 16,
   parameter int THR_STEP = 4,
   localparam int AW      = $clog2(DEPTH),
   localparam int PW      = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         thr_code,
   input  logic               clr,
   input  logic [PW-1:0]      wptr_bin,
   input  logic               ovr_tog_s,
   input  eb_entry_t          rdata,
   output logic [AW-1:0]      raddr,
   output logic [PW-1:0]      rptr_gray,
   output logic               out_valid,
   output logic [DIBIT_W-1:0] out_dibit,
   output logic               stat_ovr,
   output logic               stat_udr
);

   logic [PW-1:0] rptr_bin, rptr_nxt, fill, thr_n;
   logic          active, err, tog_q;
   logic          empty, ovr_evt, udr_evt, err_n;

   assign fill     = wptr_bin - rptr_bin;
   assign empty    = (fill == '0);
   assign thr_n    = PW'(start_bits(thr_code, THR_STEP) / DIBIT_W);
   assign rptr_nxt = rptr_bin + PW'(1);
   assign raddr    = rptr_bin[AW-1:0];
   assign ovr_evt  = ovr_tog_s ^ tog_q;
   assign udr_evt  = active & empty;
   assign err_n    = err | (active & ovr_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_bin  <= '0;
         rptr_gray <= '0;
         active    <= 1'b0;
         err       <= 1'b0;
         tog_q     <= 1'b0;
         out_valid <= 1'b0;
         out_dibit <= '0;
         stat_ovr  <= 1'b0;
         stat_udr  <= 1'b0;
      end else begin
         tog_q    <= ovr_tog_s;
         stat_ovr <= ovr_evt | (stat_ovr & ~clr);
         stat_udr <= udr_evt | (stat_udr & ~clr);
         if (!active) begin
            out_valid <= 1'b0;
            err       <= 1'b0;
            if (fill >= thr_n) active <= 1'b1;
         end else if (!empty) begin
            rptr_bin  <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (rdata.eop) begin
               active    <= 1'b0;
               out_valid <= 1'b0;
               err       <= 1'b0;
            end else begin
               out_valid <= 1'b1;
               out_dibit <= rdata.d ^ {DIBIT_W{err_n}};
               err       <= err_n;
            end
         end else begin
            // starved inside a packet: keep valid, corrupt from here on
            out_valid <= 1'b1;
            err       <= 1'b1;
            if (!err) out_dibit <= ~out_dibit;
         end
      end
   end

   assert_fill_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      fill <= PW'(DEPTH))
      else $error("read side sees more than the FIFO depth");

   assert_start_level_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(fill, 2) >= $past(thr_n, 2))
      else $error("output started below the start level");

   assert_udr_holds_valid_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_udr) |-> out_valid)
      else $error("valid dropped on underrun");

   assert_ovr_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      stat_ovr && !clr |=> stat_ovr)
      else $error("overrun flag lost without clear");

   assert_udr_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      stat_udr && !clr |=> stat_udr)
      else $error("underrun flag lost without clear");

endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic import rmii_eb_pkg::*; #(
   parameter int DEPTH_BITS  = 32,
   parameter int THR_STEP    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       rx_clk,
   input  logic       rx_rst_n,
   input  logic       rx_valid,
   input  logic [1:0] rx_dibit,
   input  logic       ref_clk,
   input  logic       ref_rst_n,
   input  logic [1:0] thr_code,
   input  logic       stat_clr,
   output logic       out_valid,
   output logic [1:0] out_dibit,
   output logic       stat_overrun,
   output logic       stat_underrun
);

   localparam int DEPTH = DEPTH_BITS / DIBIT_W;
   localparam int AW    = $clog2(DEPTH);
   localparam int PW    = AW + 1;
   localparam int EW    = $bits(eb_entry_t);

   generate
      if (DEPTH_BITS % DIBIT_W != 0) begin : g_bad_width
         $error("DEPTH_BITS must be a whole number of dibits");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO depth in dibits must be a power of two");
      end
      if (THR_STEP % DIBIT_W != 0) begin : g_bad_step
         $error("THR_STEP must be a whole number of dibits");
      end
      if (DEPTH_BITS <= 4 * THR_STEP) begin : g_bad_room
         $error("FIFO must hold more than the largest start level");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least two");
      end
   endgenerate

   eb_entry_t     w_entry, r_entry;
   logic          we, ovr_tog, ovr_tog_s;
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wptr_gray, rptr_gray, wptr_s, rptr_s;

   eb_mem #(.DEPTH(DEPTH), .EW(EW)) u_mem (
      .wclk(rx_clk), .we(we), .waddr(waddr), .wdata(w_entry),
      .raddr(raddr), .rdata(r_entry)
   );

   eb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk(rx_clk), .rst_n(rx_rst_n), .rx_valid(rx_valid), .rx_dibit(rx_dibit),
      .rptr_bin(rptr_s), .we(we), .waddr(waddr), .wdata(w_entry),
      .wptr_gray(wptr_gray), .ovr_tog(ovr_tog)
   );

   eb_sync #(.W(PW), .STAGES(SYNC_STAGES), .GRAY(1)) u_sync_r2w (
      .clk(rx_clk), .rst_n(rx_rst_n), .d(rptr_gray), .q(rptr_s)
   );

   eb_sync #(.W(PW), .STAGES(SYNC_STAGES), .GRAY(1)) u_sync_w2r (
      .clk(ref_clk), .rst_n(ref_rst_n), .d(wptr_gray), .q(wptr_s)
   );

   eb_sync #(.W(1), .STAGES(SYNC_STAGES), .GRAY(0)) u_sync_ovr (
      .clk(ref_clk), .rst_n(ref_rst_n), .d(ovr_tog), .q(ovr_tog_s)
   );

   eb_rd_ctrl #(.DEPTH(DEPTH), .THR_STEP(THR_STEP)) u_rd (
      .clk(ref_clk), .rst_n(ref_rst_n), .thr_code(thr_code), .clr(stat_clr),
      .wptr_bin(wptr_s), .ovr_tog_s(ovr_tog_s), .rdata(r_entry),
      .raddr(raddr), .rptr_gray(rptr_gray), .out_valid(out_valid),
      .out_dibit(out_dibit), .stat_ovr(stat_overrun), .stat_udr(stat_underrun)
   );

endmodule

// File: tb/rmii_rx_elastic_bench.sv
`timescale 1ns/10ps
module rmii_rx_elastic_bench;

   localparam int CLK_PERIOD_NS = 20;
   localparam int WD_CYCLES     = 150000;

   logic       ref_clk = 1'b0, rx_clk = 1'b0;
   logic       ref_rst_n = 1'b0, rx_rst_n = 1'b0;
   logic       rx_valid = 1'b0, stat_clr = 1'b0;
   logic [1:0] rx_dibit = 2'b00, thr_code = 2'b00;
   logic       out_valid, stat_overrun, stat_underrun;
   logic [1:0] out_dibit;

   bit         wfree = 1'b0;
   bit         done = 1'b0;
   int         n_chk = 0, n_fail = 0;
   int         rises = 0;
   logic       ov_q = 1'b0;
   logic [1:0] got[$];
   logic [1:0] sent[$];

   rmii_rx_elastic u_rmii_rx_elastic (
      .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_valid(rx_valid), .rx_dibit(rx_dibit),
      .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .thr_code(thr_code), .stat_clr(stat_clr),
      .out_valid(out_valid), .out_dibit(out_dibit),
      .stat_overrun(stat_overrun), .stat_underrun(stat_underrun)
   );

   always #(CLK_PERIOD_NS / 2) ref_clk = ~ref_clk;

   // free-running recovered clock, slightly faster than the reference
   initial forever begin
      if (wfree) begin
         #9.95 rx_clk = 1'b1;
         #9.95 rx_clk = 1'b0;
      end else #1;
   end

   // output monitor, sampled away from the active edge
   always @(negedge ref_clk) begin
      if (out_valid) got.push_back(out_dibit);
      if (out_valid && !ov_q) rises++;
      ov_q = out_valid;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wtick(input realtime h);
      rx_clk = 1'b1;
      #h;
      rx_clk = 1'b0;
      #h;
   endtask

   task automatic wait_idle();
      int k = 0;
      @(negedge ref_clk);
      while (out_valid && k < 3000) begin
         @(negedge ref_clk);
         k++;
      end
      repeat (6) @(negedge ref_clk);
   endtask

   task automatic prep(input logic [1:0] code);
      thr_code = code;
      @(negedge ref_clk) stat_clr = 1'b1;
      @(negedge ref_clk) stat_clr = 1'b0;
      repeat (2) @(negedge ref_clk);
      got.delete();
      sent.delete();
      rises = 0;
   endtask

   function automatic logic [1:0] pat(input int kind, input int i);
      case (kind)
         0: return 2'(i);
         1: return (i % 2 == 0) ? 2'b01 : 2'b10;
         2: return 2'b11;
         default: return 2'((i * 5 + 3) >> 1);
      endcase
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge ref_clk);
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      ref_rst_n = 1'b1;
      rx_rst_n  = 1'b1;
      repeat (3) @(negedge ref_clk);
      chk("R1", "out_valid after reset", int'(out_valid), 0);
      chk("R1", "flags after reset", int'({stat_overrun, stat_underrun}), 0);
   endtask

   // R2 R4 R5: clean packet with both clocks running
   task automatic t_clean(input logic [1:0] code, input int kind, input int n);
      int bad = 0;
      prep(code);
      wfree = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge rx_clk);
         rx_valid = 1'b1;
         rx_dibit = pat(kind, i);
         sent.push_back(rx_dibit);
      end
      @(negedge rx_clk) rx_valid = 1'b0;
      repeat (3) @(negedge rx_clk);
      wait_idle();
      chk("R5", "dibit count", got.size(), n);
      for (int i = 0; i < n && i < got.size(); i++) if (got[i] !== sent[i]) bad++;
      chk("R2 R4", "order or value mismatches", bad, 0);
      chk("R5", "valid rises per packet", rises, 1);
      chk("R5", "valid low after drain", int'(out_valid), 0);
      chk("R4", "no fault flags", int'({stat_overrun, stat_underrun}), 0);
   endtask

   // R3 R6 R8: start level, then starve the buffer by stopping the write clock
   task automatic t_start_and_underrun(input logic [1:0] code);
      int thrn, bad, stray;
      wfree = 1'b0;
      #50;
      prep(code);
      thrn = ((code == 2'd0) ? 16 : int'(code) * 4) / 2;
      for (int i = 0; i < thrn - 1; i++) begin
         rx_valid = 1'b1;
         rx_dibit = (i == thrn - 2 && thrn == 2) ? 2'b00 : pat(0, i + 1);
         sent.push_back(rx_dibit);
         wtick(10);
      end
      repeat (30) @(negedge ref_clk);
      chk("R3", "valid below start level", int'(out_valid), 0);
      chk("R3", "dibits out below start level", got.size(), 0);
      rx_dibit = 2'b00;
      sent.push_back(rx_dibit);
      wtick(10);
      repeat (30) @(negedge ref_clk);
      chk("R3", "dibits out once level reached", int'(got.size() > thrn), 1);
      bad = 0;
      for (int i = 0; i < thrn && i < got.size(); i++) if (got[i] !== sent[i]) bad++;
      chk("R3 R4", "mismatches before underrun", bad, 0);
      chk("R6", "first held dibit", int'(got.size() > thrn ? got[thrn] : 2'b00), 3);
      chk("R6", "underrun flag", int'(stat_underrun), 1);
      chk("R6", "valid held while starved", int'(out_valid), 1);
      for (int i = 0; i < 3; i++) begin
         rx_dibit = 2'b01;
         wtick(10);
      end
      repeat (10) @(negedge ref_clk);
      rx_valid = 1'b0;
      wtick(10);
      wtick(10);
      wait_idle();
      stray = 0;
      for (int i = thrn; i < got.size(); i++) if (got[i] != 2'b11 && got[i] != 2'b10) stray++;
      chk("R6", "uncomplemented dibits after underrun", stray, 0);
      chk("R6", "last dibit complemented", int'(got[got.size() - 1]), 2);
      chk("R6", "valid low at end marker", int'(out_valid), 0);
      chk("R7", "no overrun flag", int'(stat_overrun), 0);
      repeat (20) @(negedge ref_clk);
      chk("R8", "underrun flag sticky", int'(stat_underrun), 1);
      @(negedge ref_clk) stat_clr = 1'b1;
      @(negedge ref_clk) stat_clr = 1'b0;
      @(negedge ref_clk);
      chk("R8", "underrun flag cleared", int'(stat_underrun), 0);
   endtask

   // R7 R9: write far faster than read so the FIFO fills
   task automatic t_overrun();
      int inv = 0;
      wfree = 1'b0;
      #50;
      prep(2'd0);
      for (int i = 0; i < 40; i++) begin
         rx_valid = 1'b1;
         rx_dibit = 2'b01;
         wtick(2);
      end
      rx_valid = 1'b0;
      for (int i = 0; i < 20; i++) wtick(2);
      wait_idle();
      chk("R7", "overrun flag", int'(stat_overrun), 1);
      chk("R7 R9", "dropped dibits (fewer out than in)", int'(got.size() < 40), 1);
      for (int i = 0; i < got.size(); i++) if (got[i] == 2'b10) inv++;
      chk("R7", "complemented dibits present", int'(inv > 0), 1);
      chk("R7", "last dibit complemented", int'(got.size() > 0 ? got[got.size() - 1] : 2'b00), 2);
      chk("R7", "valid held until end marker", rises, 1);
      chk("R5", "valid low after drain", int'(out_valid), 0);
      @(negedge ref_clk) stat_clr = 1'b1;
      @(negedge ref_clk) stat_clr = 1'b0;
      @(negedge ref_clk);
      chk("R8", "overrun flag cleared", int'(stat_overrun), 0);
   endtask

   initial begin
      t_reset();
      t_clean(2'd1, 0, 40);
      t_clean(2'd2, 1, 40);
      t_clean(2'd3, 2, 40);
      t_clean(2'd0, 3, 40);
      t_start_and_underrun(2'd1);
      t_start_and_underrun(2'd0);
      t_overrun();
      t_clean(2'd2, 0, 30);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(WD_CYCLES * CLK_PERIOD_NS);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule